// File: doc/BRIEF.md
# Register Rename Map with Per-Instruction Checkpoints

This block translates the architectural register numbers of a group of up to four instructions into physical register numbers. It sits just before the issue queue, and the queue receives the physical numbers it produces. Every instruction that writes a register receives a fresh physical register from a free list. This removes write-after-read and write-after-write hazards. Results live in a separate physical register file, so the reorder buffer keeps only bookkeeping and no data. Each renamed instruction also reports the physical register that its destination used before. The reorder buffer hands that number back on commit, and the register then returns to the free list.

Each renamed instruction gets a circular tag. For every tag the block stores a full copy of the map table as it stood right after that instruction renamed, together with the matching free-list read position. A recovery request that names a tag can therefore undo every younger instruction in one cycle, whether the cause is a mispredicted branch or an exception. Architectural register 31 is the zero register. It always maps to physical register 31 and never receives a new mapping.

The input and output are valid/ready streams. A group moves into the block on a cycle where `in_valid` and `in_ready` are both high. It appears on the output one cycle later and stays there, unchanged, until a cycle where `out_ready` is high. `in_ready` is computed from the block state and from the group currently on the input. It can fall when the output register is still occupied, when the free list cannot cover the group, when the tag space would overflow, or during a recovery. Commit and recovery are plain one-cycle strobes. `CKPTS` must be a power of two.

Top module: `rn_rename_map`

## Requirements
- R1: A group is accepted on a clock edge where in_valid and in_ready are both high. Its results show on the output with out_valid high after that edge. While out_valid is high and out_ready is low, the output holds its values. in_ready is low while the output is occupied and out_ready is low.
- R2: An enabled lane's source physical numbers equal the current map entries. After reset, architectural register a maps to physical register a, for a from 0 to 31.
- R3: A lane source that names the destination of an earlier enabled lane in the same group receives that lane's new physical register. If several earlier lanes write it, the nearest one wins.
- R4: Enabled lanes with a destination other than 31 take new physical registers in lane order, from the head of a FIFO free list. After reset the free list holds 32, 33, ..., PHYS_REGS-1 in that order.
- R5: Each enabled lane reports as out_pold the mapping its destination had just before that lane renamed, including a mapping made by an earlier lane of the same group.
- R6: Source 31 always yields physical register 31. Destination 31 allocates nothing, and both out_pdst and out_pold are 31 for that lane.
- R7: in_ready is low when the free list holds fewer registers than the number of enabled lanes whose destination is not 31.
- R8: Enabled lanes receive consecutive tags modulo CKPTS in lane order, continuing from the previous group. in_ready is low when the in-flight count (renamed but not yet committed) plus the number of enabled lanes would exceed CKPTS.
- R9: A cmt_valid pulse retires the oldest in-flight instruction. If cmt_pold is not 31, that register is appended to the tail of the free list.
- R10: A rec_valid pulse with tag T restores the map to its state right after instruction T renamed. The registers taken by younger instructions go back to the head of the free list in their original order. The next tag becomes T+1, a pending output group is dropped, and in_ready is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Rename group present |
| in_ready | output | 1 | Group will be accepted at the next edge |
| in_lane_en | input | 4 | Per-lane enable |
| in_src1 | input | 4x5 | First architectural source per lane |
| in_src2 | input | 4x5 | Second architectural source per lane |
| in_dst | input | 4x5 | Architectural destination per lane (31 = none) |
| out_valid | output | 1 | Renamed group present |
| out_ready | input | 1 | Issue side takes the group |
| out_lane_en | output | 4 | Lane enables of the renamed group |
| out_psrc1 | output | 4xPREG_W | Physical first source |
| out_psrc2 | output | 4xPREG_W | Physical second source |
| out_pdst | output | 4xPREG_W | New physical destination |
| out_pold | output | 4xPREG_W | Previous physical mapping of the destination |
| out_tag | output | 4xTAG_W | Instruction tag per lane |
| cmt_valid | input | 1 | Oldest instruction commits |
| cmt_pold | input | PREG_W | Previous mapping released by that commit |
| rec_valid | input | 1 | Restore to a checkpoint |
| rec_tag | input | TAG_W | Tag of the last surviving instruction |

## Verification
A fixed group that chains one destination through the later lanes and uses register 31 on both sides shows whether intra-group forwarding, old-mapping reporting and zero-register handling work or fall back to stale table entries. One run fills the free list with destination-heavy groups and no commits, so it reaches the register-count stall. A second run sends groups with no destinations, so it reaches the tag-space stall, and the two stall causes are told apart. A long random phase with a narrow set of register numbers then mixes back-pressure, commits and recoveries to random in-flight tags. Each later allocation shows whether committed registers were appended at the tail and whether rewound registers came back in their original order.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int LANES     = 4;
  localparam int AREG_W    = 5;
  localparam int NUM_AREGS = 32;
  localparam int ZERO_AREG = 31;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
#(
  parameter int PHYS_REGS = 80,
  parameter int PREG_W    = $clog2(PHYS_REGS),
  parameter int FREE_N    = PHYS_REGS - NUM_AREGS,
  parameter int PTR_W     = $clog2(FREE_N) + 1,
  parameter int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [CNT_W-1:0]                   alloc_n,
  output logic [LANES-1:0][PREG_W-1:0]       peek,
  output logic [PTR_W-1:0]                   count,
  output logic [PTR_W-1:0]                   head,
  input  logic                               push_en,
  input  logic [PREG_W-1:0]                  push_preg,
  input  logic                               rewind_en,
  input  logic [PTR_W-1:0]                   rewind_head
);
  localparam int IDX_W = PTR_W - 1;
  localparam int DEPTH = 1 << IDX_W;

  logic [PREG_W-1:0] ring [DEPTH];
  logic [PTR_W-1:0]  tail;

  assign count = tail - head;

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    logic [PTR_W-1:0] slot;
    assign slot    = head + PTR_W'(g);
    assign peek[g] = ring[slot[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= PTR_W'(FREE_N);
      for (int j = 0; j < DEPTH; j++) begin
        if (j < FREE_N) ring[j] <= PREG_W'(NUM_AREGS + j);
        else            ring[j] <= '0;
      end
    end else begin
      if (push_en) begin
        ring[tail[IDX_W-1:0]] <= push_preg;
        tail <= tail + 1'b1;
      end
      if (rewind_en) head <= rewind_head;
      else           head <= head + PTR_W'(alloc_n);
    end
  end

  assert_alloc_covered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(alloc_n) <= count);
  assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PTR_W'(FREE_N));
  assert_push_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> count < PTR_W'(FREE_N));
  assert_rewind_span_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_en |-> (PTR_W'(head - rewind_head) <= PTR_W'(FREE_N) - count));
endmodule

// File: rtl/rn_map_chain.sv
module rn_map_chain
  import rn_pkg::*;
#(
  parameter int PREG_W = 7,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic [NUM_AREGS-1:0][PREG_W-1:0]            map_cur,
  input  logic [LANES-1:0]                            lane_en,
  input  logic [LANES-1:0][AREG_W-1:0]                src1,
  input  logic [LANES-1:0][AREG_W-1:0]                src2,
  input  logic [LANES-1:0][AREG_W-1:0]                dst,
  input  logic [LANES-1:0][PREG_W-1:0]                peek,
  output logic [LANES-1:0][PREG_W-1:0]                psrc1,
  output logic [LANES-1:0][PREG_W-1:0]                psrc2,
  output logic [LANES-1:0][PREG_W-1:0]                pdst,
  output logic [LANES-1:0][PREG_W-1:0]                pold,
  output logic [LANES-1:0][NUM_AREGS-1:0][PREG_W-1:0] snap,
  output logic [LANES-1:0][CNT_W-1:0]                 tag_off,
  output logic [LANES-1:0][CNT_W-1:0]                 alloc_after,
  output logic [CNT_W-1:0]                            alloc_n,
  output logic [CNT_W-1:0]                            lane_cnt
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [NUM_AREGS-1:0][PREG_W-1:0] m;
  logic [CNT_W-1:0] k;
  logic [CNT_W-1:0] t;

  // Each lane reads the map as left by the lanes before it, which
  // gives forwarding of same-group destinations without comparators.
  always_comb begin
    m = map_cur;
    k = '0;
    t = '0;
    for (int i = 0; i < LANES; i++) begin
      psrc1[i]   = m[src1[i]];
      psrc2[i]   = m[src2[i]];
      pold[i]    = m[dst[i]];
      tag_off[i] = t;
      if (lane_en[i] && dst[i] != AREG_W'(ZERO_AREG)) begin
        pdst[i]   = peek[k[LW-1:0]];
        m[dst[i]] = peek[k[LW-1:0]];
        k         = k + 1'b1;
      end else begin
        pdst[i] = PREG_W'(ZERO_AREG);
      end
      if (lane_en[i]) t = t + 1'b1;
      snap[i]        = m;
      alloc_after[i] = k;
    end
    alloc_n  = k;
    lane_cnt = t;
  end
endmodule

// File: rtl/rn_ckpt_store.sv
module rn_ckpt_store
  import rn_pkg::*;
#(
  parameter int CKPTS  = 32,
  parameter int PREG_W = 7,
  parameter int PTR_W  = 7,
  parameter int TAG_W  = $clog2(CKPTS)
) (
  input  logic                                        clk,
  input  logic [LANES-1:0]                            wr_en,
  input  logic [LANES-1:0][TAG_W-1:0]                 wr_tag,
  input  logic [LANES-1:0][NUM_AREGS-1:0][PREG_W-1:0] wr_map,
  input  logic [LANES-1:0][PTR_W-1:0]                 wr_head,
  input  logic [TAG_W-1:0]                            rd_tag,
  output logic [NUM_AREGS-1:0][PREG_W-1:0]            rd_map,
  output logic [PTR_W-1:0]                            rd_head
);
  logic [NUM_AREGS-1:0][PREG_W-1:0] snap_map  [CKPTS];
  logic [PTR_W-1:0]                 snap_head [CKPTS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_en[i]) begin
        snap_map[wr_tag[i]]  <= wr_map[i];
        snap_head[wr_tag[i]] <= wr_head[i];
      end
    end
  end

  assign rd_map  = snap_map[rd_tag];
  assign rd_head = snap_head[rd_tag];
endmodule

// File: rtl/rn_rename_map.sv
module rn_rename_map
  import rn_pkg::*;
#(
  parameter int PHYS_REGS = 80,
  parameter int CKPTS     = 32,
  parameter int PREG_W    = $clog2(PHYS_REGS),
  parameter int TAG_W     = $clog2(CKPTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [LANES-1:0]                 in_lane_en,
  input  logic [LANES-1:0][AREG_W-1:0]     in_src1,
  input  logic [LANES-1:0][AREG_W-1:0]     in_src2,
  input  logic [LANES-1:0][AREG_W-1:0]     in_dst,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [LANES-1:0]                 out_lane_en,
  output logic [LANES-1:0][PREG_W-1:0]     out_psrc1,
  output logic [LANES-1:0][PREG_W-1:0]     out_psrc2,
  output logic [LANES-1:0][PREG_W-1:0]     out_pdst,
  output logic [LANES-1:0][PREG_W-1:0]     out_pold,
  output logic [LANES-1:0][TAG_W-1:0]      out_tag,
  input  logic                             cmt_valid,
  input  logic [PREG_W-1:0]                cmt_pold,
  input  logic                             rec_valid,
  input  logic [TAG_W-1:0]                 rec_tag
);
  localparam int FREE_N = PHYS_REGS - NUM_AREGS;
  localparam int PTR_W  = $clog2(FREE_N) + 1;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int IFW    = TAG_W + 1;

  logic [NUM_AREGS-1:0][PREG_W-1:0] map_q;
  logic [IFW-1:0] alloc_ptr, cmt_ptr, inflight;

  logic [LANES-1:0][PREG_W-1:0]                psrc1, psrc2, pdst, pold, peek;
  logic [LANES-1:0][NUM_AREGS-1:0][PREG_W-1:0] snap;
  logic [LANES-1:0][CNT_W-1:0]                 tag_off, alloc_after;
  logic [CNT_W-1:0]                            alloc_n, lane_cnt;
  logic [PTR_W-1:0]                            fl_count, fl_head, rd_head;
  logic [NUM_AREGS-1:0][PREG_W-1:0]            rd_map;
  logic [LANES-1:0]                            wr_en;
  logic [LANES-1:0][TAG_W-1:0]                 wr_tag;
  logic [LANES-1:0][PTR_W-1:0]                 wr_head;
  logic                                        accept;
  logic [TAG_W-1:0]                            rec_dist;

  rn_map_chain #(.PREG_W(PREG_W), .CNT_W(CNT_W)) u_chain (
    .map_cur(map_q), .lane_en(in_lane_en), .src1(in_src1), .src2(in_src2),
    .dst(in_dst), .peek(peek), .psrc1(psrc1), .psrc2(psrc2), .pdst(pdst),
    .pold(pold), .snap(snap), .tag_off(tag_off), .alloc_after(alloc_after),
    .alloc_n(alloc_n), .lane_cnt(lane_cnt)
  );

  rn_free_list #(.PHYS_REGS(PHYS_REGS), .PREG_W(PREG_W), .FREE_N(FREE_N),
                 .PTR_W(PTR_W), .CNT_W(CNT_W)) u_free (
    .clk(clk), .rst_n(rst_n),
    .alloc_n(accept ? alloc_n : CNT_W'(0)),
    .peek(peek), .count(fl_count), .head(fl_head),
    .push_en(cmt_valid && cmt_pold != PREG_W'(ZERO_AREG)),
    .push_preg(cmt_pold),
    .rewind_en(rec_valid), .rewind_head(rd_head)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_wr
    assign wr_en[g]   = accept && in_lane_en[g];
    assign wr_tag[g]  = alloc_ptr[TAG_W-1:0] + TAG_W'(tag_off[g]);
    assign wr_head[g] = fl_head + PTR_W'(alloc_after[g]);
  end

  rn_ckpt_store #(.CKPTS(CKPTS), .PREG_W(PREG_W), .PTR_W(PTR_W),
                  .TAG_W(TAG_W)) u_ckpt (
    .clk(clk), .wr_en(wr_en), .wr_tag(wr_tag), .wr_map(snap),
    .wr_head(wr_head), .rd_tag(rec_tag), .rd_map(rd_map), .rd_head(rd_head)
  );

  assign inflight = alloc_ptr - cmt_ptr;
  assign in_ready = !rec_valid && (!out_valid || out_ready)
                  && (fl_count >= PTR_W'(alloc_n))
                  && (int'(inflight) + int'(lane_cnt) <= CKPTS);
  assign accept   = in_valid && in_ready;
  assign rec_dist = rec_tag - cmt_ptr[TAG_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_AREGS; a++) map_q[a] <= PREG_W'(a);
      alloc_ptr <= '0;
      cmt_ptr   <= '0;
      out_valid <= 1'b0;
    end else begin
      if (cmt_valid) cmt_ptr <= cmt_ptr + 1'b1;
      if (rec_valid) begin
        map_q     <= rd_map;
        alloc_ptr <= cmt_ptr + IFW'(rec_dist) + 1'b1;
        out_valid <= 1'b0;
      end else if (accept) begin
        map_q     <= snap[LANES-1];
        alloc_ptr <= alloc_ptr + IFW'(lane_cnt);
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_lane_en <= in_lane_en;
      out_psrc1   <= psrc1;
      out_psrc2   <= psrc2;
      out_pdst    <= pdst;
      out_pold    <= pold;
      out_tag     <= wr_tag;
    end
  end

  assert_out_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rec_valid) |=>
      (out_valid && $stable(out_pdst) && $stable(out_psrc1) && $stable(out_tag)));
  assert_inflight_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inflight) <= CKPTS);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_zero_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_lane_en[g]) |->
        ((out_pdst[g] == PREG_W'(ZERO_AREG)) == (out_pold[g] == PREG_W'(ZERO_AREG))));
    assert_fresh_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_lane_en[g] && out_pdst[g] != PREG_W'(ZERO_AREG)) |->
        (out_pdst[g] != out_pold[g]));
  end
endmodule

// File: tb/rn_rename_map_test.sv
module rn_rename_map_test;
  localparam int CLK_PERIOD = 10;
  localparam int PHYS = 56;
  localparam int CK   = 32;
  localparam int PW   = 6;
  localparam int TW   = 5;
  localparam int L    = 4;
  localparam int FREE0 = PHYS - 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [L-1:0] in_lane_en = '0, out_lane_en;
  logic [L-1:0][4:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [L-1:0][PW-1:0] out_psrc1, out_psrc2, out_pdst, out_pold;
  logic [L-1:0][TW-1:0] out_tag;
  logic cmt_valid = 0, rec_valid = 0;
  logic [PW-1:0] cmt_pold = '0;
  logic [TW-1:0] rec_tag = '0;

  rn_rename_map #(.PHYS_REGS(PHYS), .CKPTS(CK)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_en(in_lane_en), .in_src1(in_src1), .in_src2(in_src2),
    .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
    .out_lane_en(out_lane_en), .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
    .out_pdst(out_pdst), .out_pold(out_pold), .out_tag(out_tag),
    .cmt_valid(cmt_valid), .cmt_pold(cmt_pold), .rec_valid(rec_valid),
    .rec_tag(rec_tag)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int mmap[32];
  int fl[8192];
  int fl_kind[8192];
  int fhead, ftail, ntag, ctag, dtag;
  int smap[CK][32];
  int shead[CK];
  int ipold[CK];
  bit exp_v;
  int exp_end;
  int e_en[L], e_s1[L], e_s2[L], e_pd[L], e_po[L], e_tg[L];
  string e_l1[L], e_l2[L], e_lpd[L];

  // knobs: mode 0 random, 1 dst-heavy, 2 no destinations, 3 fixed group
  int mode, p_valid, p_ordy, p_cmt, p_rec;
  int fx_s1[L], fx_s2[L], fx_d[L];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rreg();
    int r = $urandom_range(9);
    return (r == 9) ? 31 : r;
  endfunction

  function automatic string src_label(input int s, input bit fw);
    if (s == 31) return "R6";
    if (fw) return "R3";
    return "R2";
  endfunction

  task automatic cycle();
    bit pop, do_rec;
    int rt, nl, nd, k, t, ti;
    bit exp_rdy;
    bit fw[32];
    string lbl;
    // observe results of the previous edge
    chk(out_valid == exp_v, "R1", "out_valid", out_valid, exp_v);
    if (out_valid && exp_v) begin
      for (int i = 0; i < L; i++) begin
        chk(out_lane_en[i] == e_en[i][0], "R1", "lane_en", out_lane_en[i], e_en[i]);
        if (e_en[i] != 0) begin
          chk(int'(out_psrc1[i]) == e_s1[i], e_l1[i], "psrc1", out_psrc1[i], e_s1[i]);
          chk(int'(out_psrc2[i]) == e_s2[i], e_l2[i], "psrc2", out_psrc2[i], e_s2[i]);
          chk(int'(out_pdst[i]) == e_pd[i], e_lpd[i], "pdst", out_pdst[i], e_pd[i]);
          chk(int'(out_pold[i]) == e_po[i], "R5", "pold", out_pold[i], e_po[i]);
          chk(int'(out_tag[i]) == e_tg[i], "R8", "tag", out_tag[i], e_tg[i]);
        end
      end
    end
    // drive the next edge
    out_ready = ($urandom_range(99) < p_ordy);
    pop = out_valid && out_ready;
    cmt_valid = (ctag < dtag) && ($urandom_range(99) < p_cmt);
    cmt_pold = PW'(ipold[ctag % CK]);
    do_rec = (p_rec > 0) && !out_valid && !exp_v && (ctag < dtag)
             && ($urandom_range(99) < p_rec);
    rt = (ctag < dtag) ? ctag + $urandom_range(dtag - ctag - 1) : 0;
    rec_valid = do_rec;
    rec_tag = TW'(rt % CK);
    for (int i = 0; i < L; i++) begin
      case (mode)
        1: begin in_lane_en[i] = 1; in_src1[i] = 5'(rreg()); in_src2[i] = 5'(rreg());
                 in_dst[i] = 5'($urandom_range(8)); end
        2: begin in_lane_en[i] = 1; in_src1[i] = 5'(rreg()); in_src2[i] = 5'(rreg());
                 in_dst[i] = 5'd31; end
        3: begin in_lane_en[i] = 1; in_src1[i] = 5'(fx_s1[i]); in_src2[i] = 5'(fx_s2[i]);
                 in_dst[i] = 5'(fx_d[i]); end
        default: begin in_lane_en[i] = ($urandom_range(99) < 85);
                 in_src1[i] = 5'(rreg()); in_src2[i] = 5'(rreg()); in_dst[i] = 5'(rreg()); end
      endcase
    end
    in_valid = !do_rec && ($urandom_range(99) < p_valid);
    #1;
    nl = 0; nd = 0;
    for (int i = 0; i < L; i++) if (in_lane_en[i]) begin
      nl++;
      if (in_dst[i] != 5'd31) nd++;
    end
    exp_rdy = !do_rec && (!out_valid || out_ready) && (ftail - fhead >= nd)
              && ((ntag - ctag) + nl <= CK);
    if (do_rec) lbl = "R10";
    else if (ftail - fhead < nd) lbl = "R7";
    else if ((ntag - ctag) + nl > CK) lbl = "R8";
    else lbl = "R1";
    chk(in_ready == exp_rdy, lbl, "in_ready", in_ready, exp_rdy);
    // advance the reference as of the coming edge
    if (pop) begin dtag = exp_end; exp_v = 0; end
    if (in_valid && exp_rdy) begin
      k = 0; t = 0;
      for (int a = 0; a < 32; a++) fw[a] = 0;
      for (int i = 0; i < L; i++) begin
        e_en[i] = in_lane_en[i];
        if (in_lane_en[i]) begin
          e_s1[i] = mmap[in_src1[i]]; e_l1[i] = src_label(in_src1[i], fw[in_src1[i]]);
          e_s2[i] = mmap[in_src2[i]]; e_l2[i] = src_label(in_src2[i], fw[in_src2[i]]);
          e_po[i] = mmap[in_dst[i]];
          if (in_dst[i] != 5'd31) begin
            e_pd[i] = fl[fhead + k];
            e_lpd[i] = (fl_kind[fhead + k] == 1) ? "R9" :
                       (fl_kind[fhead + k] == 2) ? "R10" : "R4";
            mmap[in_dst[i]] = e_pd[i];
            fw[in_dst[i]] = 1;
            k++;
          end else begin
            e_pd[i] = 31; e_lpd[i] = "R6";
          end
          ti = (ntag + t) % CK;
          e_tg[i] = ti;
          ipold[ti] = e_po[i];
          for (int a = 0; a < 32; a++) smap[ti][a] = mmap[a];
          shead[ti] = fhead + k;
          t++;
        end
      end
      fhead += k; ntag += t; exp_v = 1; exp_end = ntag;
    end
    if (cmt_valid) begin
      if (cmt_pold != PW'(31)) begin
        fl[ftail] = cmt_pold; fl_kind[ftail] = 1; ftail++;
      end
      ctag++;
    end
    if (do_rec) begin
      for (int a = 0; a < 32; a++) mmap[a] = smap[rt % CK][a];
      for (int j = shead[rt % CK]; j < fhead; j++) fl_kind[j] = 2;
      fhead = shead[rt % CK];
      ntag = rt + 1; dtag = rt + 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) cycle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int a = 0; a < 32; a++) mmap[a] = a;
    for (int j = 0; j < FREE0; j++) begin fl[j] = 32 + j; fl_kind[j] = 0; end
    fhead = 0; ftail = FREE0; ntag = 0; ctag = 0; dtag = 0; exp_v = 0; exp_end = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: empty output, ready for an empty group
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R2", "reset in_ready", in_ready, 1);

    // fixed group: chained destination, zero register on both sides (R3 R5 R6)
    fx_d[0] = 1;  fx_s1[0] = 2; fx_s2[0] = 3;
    fx_d[1] = 4;  fx_s1[1] = 1; fx_s2[1] = 1;
    fx_d[2] = 1;  fx_s1[2] = 4; fx_s2[2] = 31;
    fx_d[3] = 31; fx_s1[3] = 1; fx_s2[3] = 5;
    mode = 3; p_valid = 100; p_ordy = 100; p_cmt = 0; p_rec = 0;
    run(1);
    mode = 0; p_valid = 0;
    run(2);

    // exhaust free registers without commits (R7)
    mode = 1; p_valid = 100;
    run(10);
    mode = 0; p_valid = 0; p_cmt = 100;
    run(40);

    // fill the tag space with destination-free groups (R8)
    mode = 2; p_valid = 100; p_cmt = 0;
    run(12);
    mode = 0; p_valid = 0; p_cmt = 100;
    run(40);

    // random mix with back-pressure, commits and recoveries (R9 R10)
    mode = 0; p_valid = 80; p_ordy = 75; p_cmt = 45; p_rec = 6;
    run(3000);
    p_valid = 0; p_rec = 0; p_cmt = 100; p_ordy = 100;
    run(40);
    finish_run();
  end
endmodule